// File: doc/BRIEF.md
# Flash Block Protection Register File

This block keeps the protection state for a flash array divided into eight blocks. It also rules on each array access against that state. Each block owns one lock byte, and a simple strobe-based register port reads and writes it. The byte carries three controls:

- A write guard, which is set at reset.
- A read mask, which makes array reads of the block come back as zero.
- A sticky freeze bit, which stops any further change to that block's byte until the next reset.

Two active-low hardware guard pins add protection on top of the registers. One covers the top block and the other covers the main blocks below it.

The command sequencer presents a block index and an operation code on the access-check port. The block answers in the same cycle. It says whether the operation may go ahead and whether read data must be forced to zero. A refused program or erase also raises a one-cycle error pulse on the following cycle, which feeds status reporting. While the array is busy with an internal write, the register port ignores every access.

Top module: `flash_prot_regs`

## Requirements
- R1: Register offset i (0 to 7) holds the lock byte of block i. Bit 0 is the write guard, bit 1 is the freeze bit and bit 2 is the read mask. A read strobe in one cycle presents the byte on `reg_rdata` in the next cycle, and `reg_rdata` is 00h in cycles that follow no read.
- R2: After reset, every lock byte reads 01h: write guard set, read mask clear, freeze clear. After reset, `acc_err` is 0 and `reg_rdata` is 00h.
- R3: A program (op 2'b01) or erase (op 2'b10) on a block whose write guard is 1 gives `acc_allow`=0 in the same cycle, and `acc_err`=1 for exactly the following cycle. A program or erase that is not blocked gives `acc_allow`=1 and no error.
- R4: A read access (op 2'b00) always gives `acc_allow`=1. `acc_zero` is 1 exactly when the addressed block's read mask is 1.
- R5: While a block's freeze bit is 1, register writes to its byte change nothing. Only reset releases it.
- R6: While `top_guard_n` is 0, program and erase on block 7 are refused whatever its register holds. Blocks 0 to 6 are unaffected by this pin.
- R7: While `main_guard_n` is 0, program and erase on blocks 0 to 6 are refused whatever their registers hold. Block 7 is unaffected by this pin.
- R8: While `busy` is 1, register writes have no effect, and a read returns 00h on the next cycle.
- R9: Offsets 8 to 15 are unused. Reads of them return 00h and writes to them change no lock byte.
- R10: Bits 7:3 of every lock byte read as 0, and written values in those bits are dropped.
- R11: With `acc_valid` low, or with op code 2'b11, `acc_allow`, `acc_zero` and `acc_err` all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, one cycle after the read strobe |
| busy | input | 1 | Internal array write in progress |
| top_guard_n | input | 1 | Top block hardware guard, active low |
| main_guard_n | input | 1 | Main blocks hardware guard, active low |
| acc_valid | input | 1 | Access check request valid |
| acc_blk | input | 3 | Block index of the access |
| acc_op | input | 2 | 00 read, 01 program, 10 erase, 11 none |
| acc_allow | output | 1 | Access permitted |
| acc_zero | output | 1 | Read data must be replaced by 00h |
| acc_err | output | 1 | One-cycle pulse after a refused program or erase |

## Verification
Directed sequences cover several situations:

- Reset values on all eight blocks.
- A byte written with every bit set, which separates the reserved bits from the three real ones.
- A frozen block that is then rewritten.
- Each guard pin aimed at both the top block and a main block, which shows that each pin covers only its own blocks.
- Busy-cycle writes followed by idle reads, which show that the write was dropped rather than delayed.

Random traffic then mixes reads, writes, busy cycles, pin levels and all four op codes. The random writes include frozen and unused offsets. The random reads check the expected byte, and the random accesses check allow, zero and the delayed error pulse against a bench model.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10,
        OP_NONE  = 2'b11
    } acc_op_e;

    // Member order gives the byte layout: rl = bit 2, ld = bit 1, wl = bit 0
    typedef struct packed {
        logic rl;
        logic ld;
        logic wl;
    } lock_t;

    localparam int LOCK_BITS = 3;
    localparam lock_t LOCK_RESET = '{rl: 1'b0, ld: 1'b0, wl: 1'b1};

endpackage

// File: rtl/lock_bank.sv
module lock_bank
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [NUM_BLOCKS-1:0] wl_vec,
    output logic [NUM_BLOCKS-1:0] rl_vec,
    output logic [NUM_BLOCKS-1:0] ld_vec
);

    lock_t wr_val;
    logic  unused_hi;

    assign wr_val    = lock_t'(wdata[LOCK_BITS-1:0]);
    assign unused_hi = ^wdata[DATA_W-1:LOCK_BITS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
        lock_t cell_d, cell_q;
        logic  hit;

        assign hit = wr_en && (addr == ADDR_W'(b));

        always_comb begin
            cell_d = cell_q;
            if (hit && !cell_q.ld) begin
                cell_d = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= LOCK_RESET;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign wl_vec[b] = cell_q.wl;
        assign rl_vec[b] = cell_q.rl;
        assign ld_vec[b] = cell_q.ld;
    end

endmodule

// File: rtl/reg_readback.sv
module reg_readback
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NUM_BLOCKS-1:0] wl_vec,
    input  logic [NUM_BLOCKS-1:0] rl_vec,
    input  logic [NUM_BLOCKS-1:0] ld_vec,
    output logic [DATA_W-1:0]     rdata
);

    localparam int BLK_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rb_state_t;

    rb_state_t st_d, st_q;
    logic      in_map;
    logic [BLK_W-1:0] idx;
    lock_t     sel;

    assign in_map = ({1'b0, addr} < (ADDR_W+1)'(NUM_BLOCKS));
    assign idx    = addr[BLK_W-1:0];

    always_comb begin
        sel    = '0;
        sel.wl = wl_vec[idx];
        sel.ld = ld_vec[idx];
        sel.rl = rl_vec[idx];
        st_d       = '0;
        if (rd_en && in_map) begin
            st_d.rdata = DATA_W'(sel);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/prot_judge.sv
module prot_judge
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int BLK_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic [BLK_W-1:0]      acc_blk,
    input  logic [1:0]            acc_op,
    input  logic [NUM_BLOCKS-1:0] wl_vec,
    input  logic [NUM_BLOCKS-1:0] rl_vec,
    input  logic                  top_guard_n,
    input  logic                  main_guard_n,
    output logic                  acc_allow,
    output logic                  acc_zero,
    output logic                  acc_err
);

    typedef struct packed {
        logic err;
    } jd_state_t;

    jd_state_t st_d, st_q;
    logic [NUM_BLOCKS-1:0] hw_lock;
    logic [NUM_BLOCKS-1:0] eff_lock;
    logic                  is_rd;
    logic                  is_mod;

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_hw
        if (b == NUM_BLOCKS - 1) begin : g_top
            assign hw_lock[b] = !top_guard_n;
        end else begin : g_main
            assign hw_lock[b] = !main_guard_n;
        end
    end

    assign eff_lock = wl_vec | hw_lock;
    assign is_rd    = acc_valid && (acc_op_e'(acc_op) == OP_READ);
    assign is_mod   = acc_valid && ((acc_op_e'(acc_op) == OP_PROG) ||
                                    (acc_op_e'(acc_op) == OP_ERASE));

    always_comb begin
        acc_allow = is_rd || (is_mod && !eff_lock[acc_blk]);
        acc_zero  = is_rd && rl_vec[acc_blk];
        st_d      = '0;
        st_d.err  = is_mod && eff_lock[acc_blk];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_err = st_q.err;

endmodule

// File: rtl/flash_prot_regs.sv
module flash_prot_regs
    import flash_prot_pkg::*;
#(
    parameter int NUM_BLOCKS = 8,
    parameter int ADDR_W     = 4,
    parameter int DATA_W     = 8,
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              top_guard_n,
    input  logic              main_guard_n,
    input  logic              acc_valid,
    input  logic [BLK_W-1:0]  acc_blk,
    input  logic [1:0]        acc_op,
    output logic              acc_allow,
    output logic              acc_zero,
    output logic              acc_err
);

    logic                  wr_en;
    logic                  rd_en;
    logic [NUM_BLOCKS-1:0] wl_vec;
    logic [NUM_BLOCKS-1:0] rl_vec;
    logic [NUM_BLOCKS-1:0] ld_vec;

    assign wr_en = reg_wr && !busy;
    assign rd_en = reg_rd && !busy;

    lock_bank #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .wl_vec(wl_vec),
        .rl_vec(rl_vec),
        .ld_vec(ld_vec)
    );

    reg_readback #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .addr  (reg_addr),
        .wl_vec(wl_vec),
        .rl_vec(rl_vec),
        .ld_vec(ld_vec),
        .rdata (reg_rdata)
    );

    prot_judge #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W)
    ) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_blk     (acc_blk),
        .acc_op      (acc_op),
        .wl_vec      (wl_vec),
        .rl_vec      (rl_vec),
        .top_guard_n (top_guard_n),
        .main_guard_n(main_guard_n),
        .acc_allow   (acc_allow),
        .acc_zero    (acc_zero),
        .acc_err     (acc_err)
    );

endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk #(
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 8,
    parameter int BLK_W      = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic                  top_guard_n,
    input logic                  main_guard_n,
    input logic                  acc_valid,
    input logic [BLK_W-1:0]      acc_blk,
    input logic [1:0]            acc_op,
    input logic                  acc_allow,
    input logic                  acc_zero,
    input logic                  acc_err,
    input logic [DATA_W-1:0]     reg_rdata,
    input logic [NUM_BLOCKS-1:0] wl_vec,
    input logic [NUM_BLOCKS-1:0] rl_vec,
    input logic [NUM_BLOCKS-1:0] ld_vec
);

    logic past_ok;
    logic mod_req;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign mod_req = acc_valid && (acc_op == 2'b01 || acc_op == 2'b10);

    AST_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (wl_vec == '1 && rl_vec == '0 && ld_vec == '0)); // R2

    AST_ERR_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mod_req && !acc_allow)) |-> acc_err); // R3

    AST_ERR_ONLY_AFTER_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && acc_err) |-> $past(mod_req && !acc_allow)); // R3

    AST_RDMASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_op == 2'b00 && rl_vec[acc_blk]) |-> (acc_zero && acc_allow)); // R4

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((((wl_vec ^ $past(wl_vec)) | (rl_vec ^ $past(rl_vec)) |
                       (ld_vec ^ $past(ld_vec))) & $past(ld_vec)) == '0)); // R5

    AST_TOP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !top_guard_n && acc_blk == BLK_W'(NUM_BLOCKS-1)) |-> !acc_allow); // R6

    AST_MAIN_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_req && !main_guard_n && acc_blk != BLK_W'(NUM_BLOCKS-1)) |-> !acc_allow); // R7

    AST_BUSY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(busy)) |-> ($stable(wl_vec) && $stable(rl_vec) && $stable(ld_vec))); // R8

    AST_BUSY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(busy)) |-> (reg_rdata == '0)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_valid || acc_op == 2'b11) |-> (!acc_allow && !acc_zero)); // R11

endmodule

bind flash_prot_regs flash_prot_chk #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W    (DATA_W),
    .BLK_W     (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .top_guard_n (top_guard_n),
    .main_guard_n(main_guard_n),
    .acc_valid   (acc_valid),
    .acc_blk     (acc_blk),
    .acc_op      (acc_op),
    .acc_allow   (acc_allow),
    .acc_zero    (acc_zero),
    .acc_err     (acc_err),
    .reg_rdata   (reg_rdata),
    .wl_vec      (wl_vec),
    .rl_vec      (rl_vec),
    .ld_vec      (ld_vec)
);

// File: tb/tb_flash_prot_regs.sv
module tb_flash_prot_regs;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       busy = 1'b0, top_guard_n = 1'b1, main_guard_n = 1'b1;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_blk = '0;
    logic [1:0] acc_op = 2'b11;
    logic       acc_allow, acc_zero, acc_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0] m_wl, m_rl, m_ld;

    always #10 clk = ~clk;

    flash_prot_regs dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .top_guard_n(top_guard_n), .main_guard_n(main_guard_n),
        .acc_valid(acc_valid), .acc_blk(acc_blk), .acc_op(acc_op),
        .acc_allow(acc_allow), .acc_zero(acc_zero), .acc_err(acc_err)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic is_mod(input logic v, input logic [1:0] op);
        return v && (op == 2'b01 || op == 2'b10);
    endfunction

    function automatic logic exp_allow(input logic v, input logic [2:0] b, input logic [1:0] op,
                                       input logic tg, input logic mg);
        if (!v || op == 2'b11) return 1'b0;
        if (op == 2'b00) return 1'b1;
        return !(m_wl[b] || ((b == 3'd7) ? !tg : !mg));
    endfunction

    function automatic logic [7:0] exp_byte(input logic [3:0] a);
        if (a >= 4'd8) return 8'h00;
        return {5'b0, m_rl[a[2:0]], m_ld[a[2:0]], m_wl[a[2:0]]};
    endfunction

    task automatic model_reset();
        m_wl = 8'hFF; m_rl = 8'h00; m_ld = 8'h00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 0; reg_rd = 0; acc_valid = 0; busy = 0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R2", "rdata after reset", reg_rdata, 8'h00);
        chk("R2", "err after reset", {7'b0, acc_err}, 8'h00);
    endtask

    // One cycle: called at a falling edge, returns at the next falling edge
    task automatic step(input logic wr, input logic rd, input logic [3:0] a, input logic [7:0] d,
                        input logic bz, input logic tg, input logic mg, input logic av,
                        input logic [2:0] b, input logic [1:0] op, input string tag);
        logic       ea, ez, e_err;
        logic [7:0] e_rd;
        string      t;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d; busy = bz;
        top_guard_n = tg; main_guard_n = mg; acc_valid = av; acc_blk = b; acc_op = op;
        ea    = exp_allow(av, b, op, tg, mg);
        ez    = av && op == 2'b00 && m_rl[b];
        e_err = is_mod(av, op) && !ea;
        e_rd  = (rd && !bz) ? exp_byte(a) : 8'h00;
        #5;
        if (tag != "") t = tag;
        else if (!av || op == 2'b11) t = "R11";
        else if (op == 2'b00) t = "R4";
        else if (b == 3'd7 && !tg) t = "R6";
        else if (b != 3'd7 && !mg) t = "R7";
        else t = "R3";
        chk(t, "acc_allow", {7'b0, acc_allow}, {7'b0, ea});
        chk((tag != "") ? tag : "R4", "acc_zero", {7'b0, acc_zero}, {7'b0, ez});
        @(posedge clk);
        if (wr && !bz && a < 4'd8 && !m_ld[a[2:0]]) begin
            m_wl[a[2:0]] = d[0]; m_ld[a[2:0]] = d[1]; m_rl[a[2:0]] = d[2];
        end
        @(negedge clk);
        chk((tag != "") ? tag : "R3", "acc_err", {7'b0, acc_err}, {7'b0, e_err});
        if (tag != "") t = tag;
        else if (rd && bz) t = "R8";
        else if (rd && a >= 4'd8) t = "R9";
        else t = "R1";
        chk(t, "reg_rdata", reg_rdata, e_rd);
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d, input logic bz, input string tag);
        step(1, 0, a, d, bz, 1, 1, 0, 0, 2'b11, tag);
    endtask

    task automatic rd_reg(input logic [3:0] a, input logic bz, input string tag);
        step(0, 1, a, 8'h00, bz, 1, 1, 0, 0, 2'b11, tag);
    endtask

    task automatic acc(input logic [2:0] b, input logic [1:0] op, input logic tg, input logic mg,
                       input string tag);
        step(0, 0, 0, 8'h00, 0, tg, mg, 1, b, op, tag);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        model_reset();
        @(negedge clk);
        do_reset();

        for (int i = 0; i < 8; i++) rd_reg(4'(i), 0, "R2");
        acc(3, 2'b01, 1, 1, "R3");
        acc(3, 2'b00, 1, 1, "R4");
        wr_reg(3, 8'h00, 0, "R1");
        acc(3, 2'b01, 1, 1, "R3");
        acc(3, 2'b10, 1, 1, "R3");
        wr_reg(2, 8'h04, 0, "R4");
        acc(2, 2'b00, 1, 1, "R4");
        acc(2, 2'b10, 1, 1, "R3");
        wr_reg(1, 8'hFF, 0, "R10");
        rd_reg(1, 0, "R10");
        wr_reg(1, 8'h00, 0, "R5");
        rd_reg(1, 0, "R5");
        acc(1, 2'b00, 1, 1, "R5");
        wr_reg(7, 8'h00, 0, "R6");
        wr_reg(0, 8'h00, 0, "R7");
        acc(7, 2'b01, 0, 1, "R6");
        acc(0, 2'b01, 0, 1, "R6");
        acc(0, 2'b10, 1, 0, "R7");
        acc(7, 2'b10, 1, 0, "R7");
        acc(6, 2'b01, 1, 0, "R7");
        wr_reg(4, 8'h00, 1, "R8");
        rd_reg(4, 0, "R8");
        rd_reg(3, 1, "R8");
        wr_reg(9, 8'h06, 0, "R9");
        rd_reg(9, 0, "R9");
        rd_reg(15, 0, "R9");
        for (int i = 0; i < 8; i++) rd_reg(4'(i), 0, "R9");
        acc(3, 2'b11, 1, 1, "R11");
        step(0, 0, 0, 0, 0, 1, 1, 0, 3, 2'b01, "R11");
        step(0, 0, 0, 0, 0, 1, 1, 0, 2, 2'b00, "R11");
        do_reset();
        rd_reg(1, 0, "R5");
        wr_reg(1, 8'h00, 0, "R5");
        rd_reg(1, 0, "R5");

        for (int n = 0; n < 3000; n++) begin
            logic       wr, rd, bz, tg, mg, av;
            logic [3:0] a;
            logic [7:0] d;
            if (n == 1500) do_reset();
            wr = ($urandom % 3) == 0;
            rd = ($urandom % 2) == 0;
            a  = 4'($urandom % 11);
            d  = 8'($urandom);
            if (($urandom % 4) != 0) d[1] = 1'b0;
            bz = ($urandom % 5) == 0;
            tg = ($urandom % 4) != 0;
            mg = ($urandom % 4) != 0;
            av = ($urandom % 6) != 0;
            step(wr, rd, a, d, bz, tg, mg, av, 3'($urandom), 2'($urandom), "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule